// File: doc/BRIEF.md
# Signaling NaN Quieting Unit

This purely combinational unit inspects one 64-bit double-precision value. It reports whether the value is a NaN and, if so, whether it is a signaling NaN. It also returns the value with any signaling NaN turned into a quiet one. A single control input picks between two encodings of the quiet/signaling distinction. In the legacy encoding, a set top fraction bit marks a signaling NaN. In the 2008 encoding, a set top fraction bit marks a quiet NaN.

When a signaling NaN is quieted, the unit raises an invalid-operation flag. The unit then rewrites only the fraction and never touches the sign or the exponent. Every other input leaves the unit unchanged and leaves the flag low: numbers, infinities and quiet NaNs. Surrounding datapath logic uses the result as the NaN to propagate. That logic chooses between operands and handles traps itself.

Top module: `snan_quieter`

## Requirements
- R1: `is_nan` is 1 exactly when the exponent field (bits 62:52) is all ones and the fraction field (bits 51:0) is nonzero; infinities (zero fraction) give 0.
- R2: `is_snan` is 1 exactly when `is_nan` is 1 and fraction bit 51 XOR `mode_2008` equals 1 (legacy mode 0: bit 51 set means signaling; 2008 mode 1: bit 51 clear means signaling).
- R3: `invalid` is 1 exactly when the input is a signaling NaN under the selected mode.
- R4: With `mode_2008` = 1 and a signaling NaN input, `result` equals the input with fraction bit 51 set and all other bits unchanged.
- R5: With `mode_2008` = 0 and a signaling NaN input, `result` equals the input with fraction bit 51 cleared. If that leaves the fraction all zero, fraction bit 50 is set instead, so the result stays a NaN.
- R6: For any input that is not a signaling NaN under the selected mode, `result` equals `op_in`.
- R7: The sign bit (63) and exponent field (62:52) of `result` always equal those of `op_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_in | input | 64 | Double-precision operand |
| mode_2008 | input | 1 | 1 selects the 2008 NaN encoding, 0 the legacy one |
| is_nan | output | 1 | Operand is a NaN |
| is_snan | output | 1 | Operand is a signaling NaN in the selected encoding |
| result | output | 64 | Operand with a signaling NaN quieted |
| invalid | output | 1 | Invalid-operation flag raised by quieting |

## Verification
The assertions watch, on every input change, five properties. Sign and exponent always pass through. Non-signaling inputs are returned untouched. `invalid` only accompanies a NaN. A quieted result in either mode is still a NaN whose bit 51 reads as quiet under that mode. The bench shows what the assertions cannot pin down: the exact payload after quieting. This includes the legacy fallback to bit 50 when only bit 51 was set, and the classification boundary between infinity, NaN and the largest finite exponent. The bench sweeps every single-bit fraction and several edge payloads across both modes, both signs and three exponent values.

// File: rtl/snan_quieter.sv
`timescale 1ns/1ps
module snan_quieter #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] op_in,
  input  logic                  mode_2008,
  output logic                  is_nan,
  output logic                  is_snan,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  invalid
);
  localparam int QBIT = FRAC_W - 1;
  localparam int FBIT = FRAC_W - 2;
  localparam logic [FRAC_W-1:0] QMASK = {{(FRAC_W-1){1'b0}}, 1'b1} << QBIT;
  localparam logic [FRAC_W-1:0] FMASK = {{(FRAC_W-1){1'b0}}, 1'b1} << FBIT;

  logic [FRAC_W-1:0] frac, frac_cleared, frac_legacy, frac_quiet;
  logic [EXP_W-1:0]  expo;

  assign frac = op_in[FRAC_W-1:0];
  assign expo = op_in[FRAC_W +: EXP_W];

  assign is_nan  = (&expo) & (|frac);
  assign is_snan = is_nan & (frac[QBIT] ^ mode_2008);
  assign invalid = is_snan;

  assign frac_cleared = frac & ~QMASK;
  assign frac_legacy  = (|frac_cleared) ? frac_cleared : FMASK;
  assign frac_quiet   = mode_2008 ? (frac | QMASK) : frac_legacy;

  assign result = is_snan ? {op_in[EXP_W+FRAC_W:FRAC_W], frac_quiet} : op_in;
endmodule

module snan_quieter_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input logic [EXP_W+FRAC_W:0] op_in,
  input logic                  mode_2008,
  input logic                  is_nan,
  input logic                  is_snan,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  invalid
);
  localparam int QBIT = FRAC_W - 1;
  always_comb begin
    if (!$isunknown({op_in, mode_2008})) begin
      a_r7_sign_exp_pass: assert (result[EXP_W+FRAC_W:FRAC_W] == op_in[EXP_W+FRAC_W:FRAC_W]);
      a_r6_passthrough: assert (is_snan || result == op_in);
      a_r3_invalid_needs_nan: assert (!invalid || is_nan);
      a_r4_quiet_2008: assert (!(is_snan && mode_2008) || result[QBIT]);
      a_r5_quiet_legacy: assert (!(is_snan && !mode_2008) ||
                                 (!result[QBIT] && (|result[FRAC_W-1:0])));
      a_r2_snan_is_nan: assert (!is_snan || is_nan);
    end
  end
endmodule

bind snan_quieter snan_quieter_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .op_in(op_in), .mode_2008(mode_2008), .is_nan(is_nan),
  .is_snan(is_snan), .result(result), .invalid(invalid));

// File: tb/snan_quieter_test.sv
`timescale 1ns/1ps
module snan_quieter_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [63:0] op_in;
  logic        mode_2008;
  logic        is_nan, is_snan, invalid;
  logic [63:0] result;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  snan_quieter uut (.op_in(op_in), .mode_2008(mode_2008), .is_nan(is_nan),
                    .is_snan(is_snan), .result(result), .invalid(invalid));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%h mode=%0d actual=%h expected=%h", req, op_in, mode_2008, act, exp);
    end
  endtask

  task automatic apply(input logic s, input logic [10:0] e, input logic [51:0] f, input logic m);
    logic en, es;
    logic [51:0] fq;
    logic [63:0] er;
    @(posedge clk);
    op_in = {s, e, f};
    mode_2008 = m;
    en = (e == 11'h7FF) && (f != 52'd0);                // R1
    es = en && (f[51] != m);                             // R2
    if (!es) er = {s, e, f};                             // R6
    else if (m) er = {s, e, f | (52'd1 << 51)};          // R4
    else begin                                           // R5
      fq = f & ~(52'd1 << 51);
      if (fq == 52'd0) fq = 52'd1 << 50;
      er = {s, e, fq};
    end
    @(negedge clk);
    chk("R1", {63'd0, is_nan}, {63'd0, en});
    chk("R2", {63'd0, is_snan}, {63'd0, es});
    chk("R3", {63'd0, invalid}, {63'd0, es});
    chk(es ? (m ? "R4" : "R5") : "R6", result, er);
    chk("R7", {52'd0, result[63:52]}, {52'd0, s, e});
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [10:0] exps [3];
    logic [51:0] pats [7];
    op_in = 64'd0; mode_2008 = 1'b0;
    exps[0] = 11'h7FF; exps[1] = 11'h7FE; exps[2] = 11'h000;
    pats[0] = 52'd0;                      // infinity / zero
    pats[1] = 52'd1 << 51;                // only bit 51: legacy fallback to bit 50
    pats[2] = 52'd1;                      // only bit 0
    pats[3] = {52{1'b1}};                 // all ones
    pats[4] = (52'd1 << 51) | 52'd1;
    pats[5] = 52'd1 << 50;
    pats[6] = 52'h7FFFFFFFFFFFF;          // all but bit 51
    @(negedge clk);
    chk("R6 reset-state result", result, 64'd0);
    chk("R1 reset-state nan", {63'd0, is_nan}, 64'd0);
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++)
        for (int e = 0; e < 3; e++) begin
          for (int p = 0; p < 7; p++) apply(s[0], exps[e], pats[p], m[0]);
          for (int b = 0; b < 52; b++) apply(s[0], exps[e], 52'd1 << b, m[0]);
          for (int b = 0; b < 52; b++) apply(s[0], exps[e], ~(52'd1 << b), m[0]);
        end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule